// File: doc/BRIEF.md
# TDM Timeslot Blocking Strobe Generator

This block walks through the 32 timeslots of a 256-bit E1-style TDM frame and raises a per-timeslot blocking strobe for each slot whose control bit is set. A bit clock and a one-cycle frame-sync pulse drive an internal slot counter. A small write port loads four 8-bit control registers, which together hold one bit per timeslot.

A mode input changes what the same 32 bits mean. In signaling mode the strobe stays low. Each bit then selects where that timeslot's signaling comes from:

- **Set:** the internal signaling registers.
- **Clear:** the serial data stream, or a dedicated signaling input when a second control input is high.

In this mode the bits are also laid out in a different order, so that each register byte interleaves channel n with channel n+16. The integrator should keep the bits for channels 1 and 17 set in signaling mode. The internal signaling registers can then insert the multiframe alignment word and the spare and alarm bits.

All outputs are registered. They move only on the clock edge that opens a timeslot, so a register write or a mode change never cuts a slot short.

Top module: `tdm_slot_strobe`

## Requirements
- R1: After reset all 32 control bits are 0 and `blk_o`, `sig_int_o` and `sig_ded_o` are low.
- R2: A write with `wr_en` high stores `wr_data` into control register `wr_addr` (0..3). In strobe mode, register k bit j controls channel 8k+j+1, so channel 1 is register 0 bit 0 and channel 32 is register 3 bit 7.
- R3: In strobe mode (`sig_mode`=0), `blk_o` equals the current channel's control bit for the whole timeslot, and `sig_int_o` and `sig_ded_o` stay low.
- R4: Each timeslot lasts 8 bit clocks. The edge that samples `fsync` high starts channel 1, and the outputs for channel 1 appear from that edge. Without `fsync`, channel 32 is followed by channel 1.
- R5: In signaling mode, channel n (1..16) reads register (n-1)/4 bit 2*((n-1) mod 4), and channel n+16 reads the bit one position above it.
- R6: In signaling mode, `blk_o` is low and `sig_int_o` equals the channel's remapped control bit.
- R7: In signaling mode, `sig_ded_o` is high exactly when the channel's remapped bit is 0 and `ded_sel` is 1. It is low in strobe mode.
- R8: Register writes and mode changes take effect only at the next timeslot start. The outputs stay stable on every edge that does not start a timeslot.
- R9: An `fsync` pulse in the middle of a frame restarts counting at channel 1 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one edge per TDM bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; high for the first bit of channel 1 |
| sig_mode | input | 1 | 0 = blocking strobe mode, 1 = signaling-source mode |
| ded_sel | input | 1 | In signaling mode, external source is the dedicated input instead of the serial stream |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | 2 | Control register index |
| wr_data | input | 8 | Control register write data |
| blk_o | output | 1 | Blocking strobe for the current timeslot |
| sig_int_o | output | 1 | Current timeslot's signaling comes from internal registers |
| sig_ded_o | output | 1 | Current timeslot's signaling comes from the dedicated input |

## Verification
The assertions check on every cycle that the outputs hold between timeslot starts and that the three outputs never conflict. They also check that the slot counter restarts on `fsync` and wraps after the last channel. Only the bench scenarios can show that each channel picks the correct bit: the straight order in strobe mode, the interleaved n/n+16 order in signaling mode, and how `ded_sel` splits the external source. The bench also covers a write landing mid-slot and deferring to the next slot, and a frame sync arriving mid-frame.

// File: rtl/tdm_slot_strobe.sv
module tdm_slot_strobe #(
  parameter int NUM_CH    = 32,
  parameter int SLOT_BITS = 8,
  parameter int REG_W     = 8,
  parameter int NUM_REGS  = NUM_CH / REG_W,
  parameter int RA_W      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             sig_mode,
  input  logic             ded_sel,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             blk_o,
  output logic             sig_int_o,
  output logic             sig_ded_o
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int BIT_W = $clog2(SLOT_BITS);
  localparam int HALF  = NUM_CH / 2;
  localparam int PAIRS = REG_W / 2;

  logic [NUM_CH-1:0] ctl_bits;
  logic [NUM_CH-1:0] alt_bits;
  logic [BIT_W-1:0]  bit_cnt;
  logic [CH_W-1:0]   ch_idx;
  logic [CH_W-1:0]   next_ch;
  logic              slot_start;
  logic              cur_bit;
  logic              cur_alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_bits <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (wr_addr == RA_W'(r)) ctl_bits[r*REG_W +: REG_W] <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    localparam int N   = c % HALF;
    localparam int SRC = (N / PAIRS) * REG_W + 2 * (N % PAIRS) + (c / HALF);
    assign alt_bits[c] = ctl_bits[SRC];
  end

  assign slot_start = fsync || (bit_cnt == BIT_W'(SLOT_BITS - 1));
  assign next_ch    = fsync ? '0 :
                      (ch_idx == CH_W'(NUM_CH - 1)) ? '0 : ch_idx + 1'b1;
  assign cur_bit    = ctl_bits[next_ch];
  assign cur_alt    = alt_bits[next_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      ch_idx  <= '0;
    end else begin
      bit_cnt <= fsync ? '0 : bit_cnt + 1'b1;
      if (slot_start) ch_idx <= next_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_o     <= 1'b0;
      sig_int_o <= 1'b0;
      sig_ded_o <= 1'b0;
    end else if (slot_start) begin
      blk_o     <= !sig_mode && cur_bit;
      sig_int_o <= sig_mode && cur_alt;
      sig_ded_o <= sig_mode && !cur_alt && ded_sel;
    end
  end

endmodule

// File: rtl/tdm_slot_strobe_chk.sv
module tdm_slot_strobe_chk #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fsync,
  input logic            slot_start,
  input logic [CH_W-1:0] ch_idx,
  input logic            blk_o,
  input logic            sig_int_o,
  input logic            sig_ded_o
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!blk_o && !sig_int_o && !sig_ded_o));

  a_r8_hold_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> ($stable(blk_o) && $stable(sig_int_o) && $stable(sig_ded_o)));

  a_r6_no_strobe_with_int: assert property (@(posedge clk) disable iff (!rst_n)
    sig_int_o |-> !blk_o);

  a_r7_ded_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    sig_ded_o |-> (!sig_int_o && !blk_o));

  a_r4_fsync_to_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (ch_idx == '0));

  a_r4_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !fsync && ch_idx == CH_W'(NUM_CH - 1)) |=> (ch_idx == '0));

endmodule

bind tdm_slot_strobe tdm_slot_strobe_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_start(slot_start),
  .ch_idx(ch_idx), .blk_o(blk_o), .sig_int_o(sig_int_o), .sig_ded_o(sig_ded_o)
);

// File: tb/tdm_slot_strobe_tb.sv
`timescale 1ns/1ps
module tdm_slot_strobe_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, sig_mode = 1'b0, ded_sel = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic blk_o, sig_int_o, sig_ded_o;

  logic [7:0] shadow [4];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tdm_slot_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sig_mode(sig_mode), .ded_sel(ded_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_o(blk_o), .sig_int_o(sig_int_o), .sig_ded_o(sig_ded_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(int c, logic alt);
    int n, b;
    if (!alt) return shadow[c / 8][c % 8];
    n = c % 16;
    b = 2 * (n % 4) + (c >= 16 ? 1 : 0);
    return shadow[n / 4][b];
  endfunction

  task automatic write_reg(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a] = d;
  endtask

  task automatic sync_now();
    @(negedge clk); fsync = 1'b1;
    @(posedge clk); #1 fsync = 1'b0;
  endtask

  // entered just after a slot-start edge; checks n slots from channel index c0
  task automatic check_slots(string req, int c0, int n);
    for (int k = 0; k < n; k++) begin
      int c = (c0 + k) % 32;
      logic b = exp_bit(c, sig_mode);
      repeat (3) @(negedge clk);
      chk(req, $sformatf("blk ch%0d", c + 1), blk_o, !sig_mode && b);
      chk(req, $sformatf("int ch%0d", c + 1), sig_int_o, sig_mode && b);
      chk(req, $sformatf("ded ch%0d", c + 1), sig_ded_o, sig_mode && !b && ded_sel);
      repeat (6) @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1", "blk after reset", blk_o, 1'b0);
    chk("R1", "int after reset", sig_int_o, 1'b0);
    chk("R1", "ded after reset", sig_ded_o, 1'b0);
    sig_mode = 1'b0;
    sync_now();
    check_slots("R1", 0, 32);
  endtask

  task automatic t_strobe_mode();
    write_reg(0, 8'hA5); write_reg(1, 8'h3C); write_reg(2, 8'h0F); write_reg(3, 8'h81);
    sig_mode = 1'b0;
    sync_now();
    check_slots("R3", 0, 32);
    check_slots("R4", 0, 32);  // no fsync: wraps to channel 1
    write_reg(0, 8'h01); write_reg(1, 8'h80); write_reg(2, 8'h00); write_reg(3, 8'hFF);
    sync_now();
    check_slots("R2", 0, 32);
  endtask

  task automatic t_sig_mode(logic d);
    write_reg(0, 8'h5B); write_reg(1, 8'hC6); write_reg(2, 8'h39); write_reg(3, 8'hE4);
    sig_mode = 1'b1; ded_sel = d;
    sync_now();
    check_slots(d ? "R7" : "R5", 0, 32);
    check_slots("R6", 0, 8);
    sig_mode = 1'b0; ded_sel = 1'b0;
  endtask

  task automatic t_midslot_write();
    write_reg(0, 8'h01);
    sig_mode = 1'b0;
    sync_now();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8", "ch1 keeps old bit after mid-slot write", blk_o, 1'b1);
    shadow[0] = 8'h02;
    repeat (2) @(posedge clk);
    #1;
    check_slots("R8", 1, 2);
  endtask

  task automatic t_resync();
    write_reg(0, 8'h0E); write_reg(1, 8'h00); write_reg(2, 8'h00); write_reg(3, 8'h00);
    sig_mode = 1'b0;
    sync_now();
    check_slots("R9", 0, 5);
    sync_now();
    check_slots("R9", 0, 4);
  endtask

  initial begin
    shadow[0] = '0; shadow[1] = '0; shadow[2] = '0; shadow[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strobe_mode();
    t_sig_mode(1'b0);
    t_sig_mode(1'b1);
    t_midslot_write();
    t_resync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule